// File: doc/BRIEF.md
# Indexed-Mask Priority Interrupt Controller

This block gathers a bank of interrupt request lines, one per source, and reports to the processor the single source that should be serviced. Each source has two pieces of state: a mask bit that blocks it, and a small priority level. On every clock the controller finds the asserted, unmasked source with the highest level. It registers that source's level and number, together with a request flag, on its outputs.

Software never rewrites the whole mask vector. It writes a source number to one of two byte-wide command addresses. One address blocks the named source and the other enables it. The value 0xFF acts on every source at once. The two commands cannot interfere with each other, because no read-modify-write of a shared register is needed. Each source's level lives in its own byte, at a fixed window base plus the source number. The bus is write-only, and every write takes effect at the clock edge where `wr_en_i` is high.

The block has no sequencing state, so it has no state machine. The mask bits, the level bytes and the output register are its only storage.

Top module: `irqc_top`

## Requirements
- R1: While reset is asserted and after it is released, every mask bit is 1 and every level is 0. Until software changes them, `irq_req_o`, `irq_level_o` and `irq_src_o` are all 0, even with every source line high.
- R2: Writing a value n (0 to NUM_SRC-1) to the block-command address 0x00 sets mask bit n. Source n then no longer requests.
- R3: Writing a value n (0 to NUM_SRC-1) to the enable-command address 0x01 clears mask bit n. Source n may then request.
- R4: Writing 0xFF to address 0x00 sets every mask bit in one write.
- R5: Writing 0xFF to address 0x01 clears every mask bit in one write.
- R6: At addresses 0x00 and 0x01, a value from NUM_SRC to 0xFE changes no mask bit.
- R7: The level byte of source n is at address 0x40+n. Its bits [2:0] are the level and bits [7:3] are discarded. Every level from 1 to 7, 5 included, is an ordinary priority.
- R8: A source whose level is 0 never requests, even when it is asserted and unmasked.
- R9: The outputs name the asserted, unmasked source with the largest level. A tie goes to the lowest source number. `irq_req_o` is 1 exactly when such a source exists. When none exists, the level and source outputs are 0.
- R10: The outputs are registered. They reflect the source lines, masks and levels as they stood just before the previous rising clock edge, so there is exactly one cycle of latency.
- R11: Writes to addresses 0x02 to 0x3F and from 0x40+NUM_SRC to 0xFF change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC (64) | Interrupt request lines, active high, one per source |
| wr_en_i | input | 1 | Write strobe for the command/level bus |
| wr_addr_i | input | 8 | Byte address: 0x00 block, 0x01 enable, 0x40+n level of source n |
| wr_data_i | input | 8 | Write data byte |
| irq_req_o | output | 1 | A source is requesting |
| irq_level_o | output | 3 | Level of the chosen source |
| irq_src_o | output | 6 | Number of the chosen source |

## Verification
The bench builds the block with its default parameters: 64 sources, 3-bit levels, and the level window at 0x40. This puts the top source number 63, the level window's last byte at 0x7F, and the first rejected command value 64 within reach of directed writes. A behavioural model keeps its own mask and level arrays and predicts the outputs every cycle. Directed writes cover ties, masking of the current winner, the global 0xFF commands and ignored values. Long random mixes of writes and line changes then exercise the arbitration.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Meaning of a byte written to one of the two mask command addresses
    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,   // value outside the source range: ignored
        IDX_ONE  = 2'd1,   // names a single source
        IDX_ALL  = 2'd2    // 0xFF: every source
    } idx_kind_e;

    typedef struct packed {
        idx_kind_e  kind;
        logic [7:0] idx;
    } idx_cmd_t;

    localparam logic [7:0] ALL_SRC_CODE = 8'hFF;

    function automatic idx_cmd_t decode_idx(input logic [7:0] v, input int unsigned nsrc);
        idx_cmd_t c;
        c.idx = v;
        if (v == ALL_SRC_CODE)
            c.kind = IDX_ALL;
        else if (32'(v) < nsrc)
            c.kind = IDX_ONE;
        else
            c.kind = IDX_NONE;
        return c;
    endfunction

endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter logic [7:0]  SETM_ADDR = 8'h00,
    parameter logic [7:0]  CLRM_ADDR = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [7:0]         wr_addr_i,
    input  logic [7:0]         wr_data_i,
    output logic [NUM_SRC-1:0] mask_o
);

    idx_cmd_t cmd;
    logic     set_hit;
    logic     clr_hit;

    always_comb begin
        cmd     = decode_idx(wr_data_i, NUM_SRC);
        set_hit = wr_en_i && (wr_addr_i == SETM_ADDR);
        clr_hit = wr_en_i && (wr_addr_i == CLRM_ADDR);
    end

    // One flop per source; each decodes the command on its own
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic sel;
        logic bit_q;

        assign sel = (cmd.kind == IDX_ALL) ||
                     ((cmd.kind == IDX_ONE) && (cmd.idx == 8'(i)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b1;
            else if (sel && set_hit)
                bit_q <= 1'b1;
            else if (sel && clr_hit)
                bit_q <= 1'b0;
        end

        assign mask_o[i] = bit_q;
    end

endmodule

// File: rtl/irqc_level_bank.sv
module irqc_level_bank #(
    parameter int unsigned NUM_SRC  = 64,
    parameter int unsigned LVL_W    = 3,
    parameter logic [7:0]  LVL_BASE = 8'h40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [7:0]                    wr_addr_i,
    input  logic [7:0]                    wr_data_i,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
        localparam logic [7:0] MY_ADDR = 8'(32'(LVL_BASE) + i);
        logic             hit;
        logic [LVL_W-1:0] lvl_q;

        assign hit = wr_en_i && (wr_addr_i == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (hit)
                lvl_q <= wr_data_i[LVL_W-1:0];
        end

        assign lvl_o[i] = lvl_q;
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned LVL_W   = 3,
    localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            src_i,
    input  logic [NUM_SRC-1:0]            mask_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    output logic [LVL_W-1:0]              win_lvl_o,
    output logic [SRC_W-1:0]              win_src_o
);

    localparam int unsigned LEAVES = 1 << SRC_W;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [SRC_W-1:0] src;
    } cand_t;

    cand_t nd [NODES];

    // Leaves: a blocked, idle or padding source enters with level 0
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            assign nd[LEAVES-1+i].lvl = (src_i[i] && !mask_i[i]) ? lvl_i[i] : '0;
            assign nd[LEAVES-1+i].src = SRC_W'(i);
        end else begin : g_pad
            assign nd[LEAVES-1+i].lvl = '0;
            assign nd[LEAVES-1+i].src = '0;
        end
    end

    // Internal nodes: the left child (lower numbers) wins ties
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        assign nd[k] = (nd[2*k+2].lvl > nd[2*k+1].lvl) ? nd[2*k+2] : nd[2*k+1];
    end

    assign win_lvl_o = nd[0].lvl;
    assign win_src_o = nd[0].src;

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned LVL_W     = 3,
    parameter logic [7:0]  SETM_ADDR = 8'h00,
    parameter logic [7:0]  CLRM_ADDR = 8'h01,
    parameter logic [7:0]  LVL_BASE  = 8'h40,
    localparam int unsigned SRC_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [7:0]         wr_addr_i,
    input  logic [7:0]         wr_data_i,
    output logic               irq_req_o,
    output logic [LVL_W-1:0]   irq_level_o,
    output logic [SRC_W-1:0]   irq_src_o
);

    logic [NUM_SRC-1:0]            mask_w;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_w;
    logic [LVL_W-1:0]              win_lvl;
    logic [SRC_W-1:0]              win_src;

    irqc_mask_bank #(
        .NUM_SRC  (NUM_SRC),
        .SETM_ADDR(SETM_ADDR),
        .CLRM_ADDR(CLRM_ADDR)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .mask_o   (mask_w)
    );

    irqc_level_bank #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .LVL_BASE(LVL_BASE)
    ) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .lvl_o    (lvl_w)
    );

    irqc_arbiter #(
        .NUM_SRC(NUM_SRC),
        .LVL_W  (LVL_W)
    ) u_arb (
        .src_i    (src_i),
        .mask_i   (mask_w),
        .lvl_i    (lvl_w),
        .win_lvl_o(win_lvl),
        .win_src_o(win_src)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req_o   <= 1'b0;
            irq_level_o <= '0;
            irq_src_o   <= '0;
        end else begin
            irq_req_o   <= (win_lvl != '0);
            irq_level_o <= win_lvl;
            irq_src_o   <= win_src;
        end
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned LVL_W     = 3,
    parameter logic [7:0]  SETM_ADDR = 8'h00,
    parameter logic [7:0]  CLRM_ADDR = 8'h01,
    localparam int unsigned SRC_W    = $clog2(NUM_SRC)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_SRC-1:0]            src_i,
    input logic                          wr_en_i,
    input logic [7:0]                    wr_addr_i,
    input logic [7:0]                    wr_data_i,
    input logic [NUM_SRC-1:0]            mask_q,
    input logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
    input logic                          irq_req_o,
    input logic [LVL_W-1:0]              irq_level_o,
    input logic [SRC_W-1:0]              irq_src_o
);

    logic set_hit, clr_hit, in_range;
    assign set_hit  = wr_en_i && (wr_addr_i == SETM_ADDR);
    assign clr_hit  = wr_en_i && (wr_addr_i == CLRM_ADDR);
    assign in_range = 32'(wr_data_i) < NUM_SRC;

    logic                          armed_q;
    logic                          set_one_d, clr_one_d, set_all_d, clr_all_d, ign_d;
    logic [SRC_W-1:0]              idx_d;
    logic [NUM_SRC-1:0]            src_d, mask_d;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            set_one_d <= 1'b0;
            clr_one_d <= 1'b0;
            set_all_d <= 1'b0;
            clr_all_d <= 1'b0;
            ign_d     <= 1'b0;
            idx_d     <= '0;
            src_d     <= '0;
            mask_d    <= '1;
            lvl_d     <= '0;
        end else begin
            armed_q   <= 1'b1;
            set_one_d <= set_hit && in_range;
            clr_one_d <= clr_hit && in_range;
            set_all_d <= set_hit && (wr_data_i == 8'hFF);
            clr_all_d <= clr_hit && (wr_data_i == 8'hFF);
            ign_d     <= (set_hit || clr_hit) && !in_range && (wr_data_i != 8'hFF);
            idx_d     <= wr_data_i[SRC_W-1:0];
            src_d     <= src_i;
            mask_d    <= mask_q;
            lvl_d     <= lvl_q;
        end
    end

    // R2
    set_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_one_d |-> mask_q[idx_d]);

    // R3
    clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_one_d |-> !mask_q[idx_d]);

    // R4
    set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_all_d |-> (&mask_q));

    // R5
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_d |-> (mask_q == '0));

    // R6
    ign_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ign_d |-> (mask_q == mask_d));

    // R8
    req_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_level_o != '0));

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_level_o == '0 && irq_src_o == '0));

    // R10
    win_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && irq_req_o) |->
            (src_d[irq_src_o] && !mask_d[irq_src_o] && lvl_d[irq_src_o] == irq_level_o));

endmodule

bind irqc_top irqc_chk #(
    .NUM_SRC  (NUM_SRC),
    .LVL_W    (LVL_W),
    .SETM_ADDR(SETM_ADDR),
    .CLRM_ADDR(CLRM_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mask_q     (mask_w),
    .lvl_q      (lvl_w),
    .irq_req_o  (irq_req_o),
    .irq_level_o(irq_level_o),
    .irq_src_o  (irq_src_o)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;

    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         irq_req;
    logic [2:0]   irq_level;
    logic [5:0]   irq_src;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Behavioural reference state
    bit mdl_mask [N];
    int mdl_lvl  [N];

    always #5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .irq_req_o  (irq_req),
        .irq_level_o(irq_level),
        .irq_src_o  (irq_src)
    );

    task automatic check(input string tag, input int er, input int el, input int es);
        n_chk++;
        if (int'(irq_req) != er || int'(irq_level) != el || int'(irq_src) != es) begin
            n_fail++;
            $display("FAIL %s: got req=%0d lvl=%0d src=%0d, expected req=%0d lvl=%0d src=%0d",
                     tag, irq_req, irq_level, irq_src, er, el, es);
        end
    endtask

    task automatic predict(output int er, output int el, output int es);
        el = 0; es = 0;
        for (int i = 0; i < N; i++)
            if (src[i] && !mdl_mask[i] && mdl_lvl[i] > el) begin
                el = mdl_lvl[i];
                es = i;
            end
        er = (el != 0) ? 1 : 0;
    endtask

    task automatic apply(input logic we, input logic [7:0] a, input logic [7:0] d);
        if (!we) return;
        if (a == 8'h00 || a == 8'h01) begin
            for (int i = 0; i < N; i++)
                if (d == 8'hFF || int'(d) == i)
                    mdl_mask[i] = (a == 8'h00);
        end else if (a >= 8'h40 && int'(a) < 8'h40 + N) begin
            mdl_lvl[int'(a) - 8'h40] = int'(d & 8'h07);
        end
    endtask

    // One clock: drive at negedge, compare just after the posedge
    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d, input string tag);
        int er, el, es;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        predict(er, el, es);
        @(posedge clk);
        #1;
        check(tag, er, el, es);
        apply(we, a, d);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 8'h00, 8'h00, tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mdl_mask[i] = 1'b1;
            mdl_lvl[i]  = 0;
        end
        src = '1;
        #23;
        check("R1", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // Levels; upper bits of the byte must be dropped
        cyc(1'b1, 8'h43, 8'h05, "R7");
        cyc(1'b1, 8'h4A, 8'hF5, "R7");
        cyc(1'b1, 8'h54, 8'hFA, "R7");
        cyc(1'b1, 8'h7F, 8'h0F, "R7");
        idle("R1");

        cyc(1'b1, 8'h01, 8'h03, "R3");
        idle("R3");
        cyc(1'b1, 8'h01, 8'h0A, "R9");
        idle("R9");
        cyc(1'b1, 8'h00, 8'h03, "R2");
        idle("R2");

        cyc(1'b1, 8'h00, 8'h40, "R6");
        cyc(1'b1, 8'h00, 8'hFE, "R6");
        cyc(1'b1, 8'h01, 8'h80, "R6");
        cyc(1'b1, 8'h01, 8'h7F, "R6");
        idle("R6");

        cyc(1'b1, 8'h02, 8'h0A, "R11");
        cyc(1'b1, 8'h80, 8'h00, "R11");
        cyc(1'b1, 8'h3F, 8'h0A, "R11");
        idle("R11");

        cyc(1'b1, 8'h01, 8'hFF, "R5");
        idle("R5");
        cyc(1'b1, 8'h00, 8'h3F, "R2");
        idle("R2");
        cyc(1'b1, 8'h01, 8'h3F, "R3");
        idle("R3");

        src[63] = 1'b0;
        idle("R10");
        idle("R10");
        src = 64'h1;
        idle("R8");
        idle("R8");
        src = '1;
        idle("R10");

        cyc(1'b1, 8'h00, 8'hFF, "R4");
        idle("R4");
        idle("R4");

        // Random mix of writes and line changes
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] a, d;
            int sel;
            sel = int'($urandom_range(0, 9));
            d = 8'($urandom());
            if (sel < 3)
                a = 8'h00;
            else if (sel < 6)
                a = 8'h01;
            else if (sel < 9)
                a = 8'(8'h40 + $urandom_range(0, N - 1));
            else
                a = 8'($urandom());
            if (sel < 6 && d[7:6] != 2'b11 && d[6]) d = {2'b00, d[5:0]};
            if ($urandom_range(0, 3) == 0)
                src = {$urandom(), $urandom()};
            cyc($urandom_range(0, 1) == 1, a, d, "R9");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule